// File: doc/BRIEF.md
# Translation Lookaside Buffer with Two-Register Test Access

This block is a small set-associative translation buffer for 4 KiB pages, reached entirely through a pair of 32-bit test registers. The data register is loaded with a physical page number, two cache-control bits and a way number. Writing the command register with its low bit clear then installs an entry into that way of the set picked by the linear page number. Writing it with the low bit set starts a lookup. One clock later the data register reports whether a valid, matching entry was found, with its physical page, cache bits and way.

Each of the three page attributes (dirty, user, writable) is given on the command register as a pair: a bit and its complement. On a lookup, the pair can demand the attribute set or clear, accept either value, or refuse every entry. Each set keeps a 3-bit tree pseudo-LRU state, which is touched by installs and lookup hits and reported back in the data register.

The port acts only while a privilege input shows supervisor or real mode. A synchronous flush input drops every entry in one cycle.

Top module: `tlb_test_port`

## Requirements
- R1: The data register reads as {phys page[31:12], cache-disable[11], write-through[10], pseudo-LRU[9:7], 0[6:5], hit[4], way[3:2], 0[1:0]}. A data write stores bits 31:10 and 3:2, clears hit and keeps the pseudo-LRU field. Bits written to 9:7, 6:4 and 1:0 are dropped.
- R2: A command write with bit 0 = 0 installs an entry into set wdata[14:12], way = data register bits 3:2. The entry takes its tag from wdata[31:15] and its valid flag from wdata[11]. Its dirty, user and writable attributes are the high bits of the pairs at 10:9, 8:7 and 6:5. Its physical page and cache bits come from the data register. An entry installed with valid 0 never hits.
- R3: A command write with bit 0 = 1 starts a lookup. busy is high during the next cycle. res_valid pulses high for exactly the cycle after that, when the data register holds the result.
- R4: A lookup hits when a valid entry of the indexed set has an equal tag and every attribute pair accepts it. It sets hit = 1 and loads the physical page, the cache bits and the way that hit.
- R5: A lookup that finds nothing clears hit. The physical page, cache bits and way field keep their values.
- R6: On a lookup, an attribute pair of 10 needs the attribute set and 01 needs it clear. A pair of 11 accepts either value, and 00 rejects every entry.
- R7: When several ways of a set match, the lowest-numbered way is reported.
- R8: Pseudo-LRU per set, with bit 7 as the root. A touch of way 0 or 1 sets bit 7 to 1; a touch of way 2 or 3 sets it to 0. A touch of way 0 sets bit 8 to 1 and of way 1 sets it to 0. A touch of way 2 sets bit 9 to 1 and of way 3 sets it to 0. Other bits are kept. Installs and lookup hits touch the set. Installs and all lookups report the set's state in bits 9:7.
- R9: While priv_ok is low, data and command writes are ignored.
- R10: While busy is high, data and command writes are ignored.
- R11: flush clears every valid flag at the next edge. It wins over an install in the same cycle.
- R12: After reset the data register reads zero, busy and res_valid are low, no entry is valid and every pseudo-LRU state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_ok | input | 1 | High in supervisor or real mode; enables the test port |
| flush | input | 1 | Invalidate all entries |
| wr_cmd | input | 1 | Write strobe for the command register |
| wr_data | input | 1 | Write strobe for the data register |
| wdata | input | 32 | Value written by either strobe |
| rd_data | output | 32 | Current data register contents |
| busy | output | 1 | Lookup in progress |
| res_valid | output | 1 | Lookup result present in rd_data |

## Verification
The lookups cover several cases. The exact attribute pattern shows that tag and attributes are compared. The all-don't-care pattern separates pair 11 from a strict compare. A single demand-set pair against a stored clear attribute, and a 00 pair against a matching entry, show that one attribute can force a miss. A lookup with an unequal tag in the same set separates tag compare from index use. A set holding the same page in two ways shows which way wins. A chain of installs and hits in one set walks the pseudo-LRU bits through known values. Gated writes (privilege low, busy, flush racing an install) are observed through the data register and through later lookups.

// File: rtl/tlb_tp_pkg.sv
package tlb_tp_pkg;
  localparam int PAGE_W = 20;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int LRU_W  = 3;

  // Command register positions (neighbour-visible layout)
  localparam int CMD_OP   = 0;
  localparam int CMD_RWP  = 5;
  localparam int CMD_USP  = 7;
  localparam int CMD_DTP  = 9;
  localparam int CMD_VLD  = 11;
  localparam int PAGE_LSB = 12;

  typedef struct packed {
    logic              dirty;
    logic              user;
    logic              wrt;
    logic [PAGE_W-1:0] ppn;
    logic              pcd;
    logic              pwt;
  } tlb_ent_t;

  typedef struct packed {
    logic [PAGE_W-1:0] ppn;
    logic              pcd;
    logic              pwt;
    logic [LRU_W-1:0]  lru;
    logic              hit;
    logic [WAY_W-1:0]  rep;
  } tdata_t;

  // Pair coding: 10 demand set, 01 demand clear, 11 either, 00 never
  function automatic logic pair_accepts(input logic [1:0] pair, input logic stored);
    case (pair)
      2'b11:   return 1'b1;
      2'b10:   return stored;
      2'b01:   return ~stored;
      default: return 1'b0;
    endcase
  endfunction

  // Tree pseudo-LRU: bit0 root, bit1 ways 0/1, bit2 ways 2/3
  function automatic logic [LRU_W-1:0] plru_touch(input logic [LRU_W-1:0] cur,
                                                  input logic [WAY_W-1:0] way);
    logic [LRU_W-1:0] nxt;
    nxt = cur;
    if (way[1] == 1'b0) begin
      nxt[0] = 1'b1;
      nxt[1] = (way[0] == 1'b0);
    end else begin
      nxt[0] = 1'b0;
      nxt[2] = (way[0] == 1'b0);
    end
    return nxt;
  endfunction

  function automatic logic [31:0] pack_data(input tdata_t d);
    return {d.ppn, d.pcd, d.pwt, d.lru, 2'b00, d.hit, d.rep, 2'b00};
  endfunction
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store
  import tlb_tp_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    we,
  input  logic [$clog2(SETS)-1:0] wset,
  input  logic [TAG_W-1:0]        wtag,
  input  logic                    wvld,
  input  tlb_ent_t                went,
  input  logic [$clog2(SETS)-1:0] rset,
  output logic                    rvld,
  output logic [TAG_W-1:0]        rtag,
  output tlb_ent_t                rent,
  output logic                    any_vld
);
  logic [SETS-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  tlb_ent_t         ent_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (we) begin
      vld_q[wset] <= wvld;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[wset] <= wtag;
      ent_q[wset] <= went;
    end
  end

  assign rvld    = vld_q[rset];
  assign rtag    = tag_q[rset];
  assign rent    = ent_q[rset];
  assign any_vld = |vld_q;
endmodule

// File: rtl/tlb_lookup_match.sv
module tlb_lookup_match
  import tlb_tp_pkg::*;
#(
  parameter int TAG_W = 17
) (
  input  logic [TAG_W-1:0]            key_tag,
  input  logic [1:0]                  dirty_pair,
  input  logic [1:0]                  user_pair,
  input  logic [1:0]                  wrt_pair,
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  tlb_ent_t [WAYS-1:0]         way_ent,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit_any,
  output logic [WAY_W-1:0]            hit_way,
  output tlb_ent_t                    hit_ent
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_vld[w] && (way_tag[w] == key_tag)
                     && pair_accepts(dirty_pair, way_ent[w].dirty)
                     && pair_accepts(user_pair,  way_ent[w].user)
                     && pair_accepts(wrt_pair,   way_ent[w].wrt);
  end

  // Lowest-numbered matching way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit_any = |hit_vec;
  assign hit_ent = way_ent[hit_way];
endmodule

// File: rtl/tlb_plru_bank.sv
module tlb_plru_bank
  import tlb_tp_pkg::*;
#(
  parameter int SETS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] set_sel,
  input  logic                    upd_en,
  input  logic [LRU_W-1:0]        upd_bits,
  output logic [LRU_W-1:0]        cur_bits
);
  logic [LRU_W-1:0] tree_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[set_sel] <= upd_bits;
    end
  end

  assign cur_bits = tree_q[set_sel];
endmodule

// File: rtl/tlb_test_port.sv
module tlb_test_port
  import tlb_tp_pkg::*;
#(
  parameter int SETS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        priv_ok,
  input  logic        flush,
  input  logic        wr_cmd,
  input  logic        wr_data,
  input  logic [31:0] wdata,
  output logic [31:0] rd_data,
  output logic        busy,
  output logic        res_valid
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = PAGE_W - SET_W;
  localparam int TAG_LSB = PAGE_LSB + SET_W;

  tdata_t      dreg_q;
  logic        lk_pend;
  logic [31:0] lk_cmd;
  logic        res_q;

  // Named internal events
  logic port_ok, data_wr_fire, cmd_wr_fire, cmd_lk_fire;
  assign port_ok      = priv_ok & ~lk_pend;
  assign data_wr_fire = port_ok & wr_data;
  assign cmd_wr_fire  = port_ok & wr_cmd & ~wdata[CMD_OP];
  assign cmd_lk_fire  = port_ok & wr_cmd &  wdata[CMD_OP];

  logic [SET_W-1:0] wr_set, lk_set, act_set;
  assign wr_set  = wdata[PAGE_LSB +: SET_W];
  assign lk_set  = lk_cmd[PAGE_LSB +: SET_W];
  assign act_set = lk_pend ? lk_set : wr_set;

  tlb_ent_t new_ent;
  assign new_ent = '{dirty: wdata[CMD_DTP+1], user: wdata[CMD_USP+1],
                     wrt: wdata[CMD_RWP+1], ppn: dreg_q.ppn,
                     pcd: dreg_q.pcd, pwt: dreg_q.pwt};

  logic [WAYS-1:0]            way_vld;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  tlb_ent_t [WAYS-1:0]        way_ent;
  logic [WAYS-1:0]            way_any;
  logic                       any_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .we      (cmd_wr_fire && (dreg_q.rep == WAY_W'(w))),
      .wset    (wr_set),
      .wtag    (wdata[31:TAG_LSB]),
      .wvld    (wdata[CMD_VLD]),
      .went    (new_ent),
      .rset    (lk_set),
      .rvld    (way_vld[w]),
      .rtag    (way_tag[w]),
      .rent    (way_ent[w]),
      .any_vld (way_any[w])
    );
  end
  assign any_valid = |way_any;

  logic [WAYS-1:0]  hit_vec;
  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  tlb_ent_t         hit_ent;

  tlb_lookup_match #(.TAG_W(TAG_W)) u_match (
    .key_tag    (lk_cmd[31:TAG_LSB]),
    .dirty_pair (lk_cmd[CMD_DTP +: 2]),
    .user_pair  (lk_cmd[CMD_USP +: 2]),
    .wrt_pair   (lk_cmd[CMD_RWP +: 2]),
    .way_vld    (way_vld),
    .way_tag    (way_tag),
    .way_ent    (way_ent),
    .hit_vec    (hit_vec),
    .hit_any    (hit_any),
    .hit_way    (hit_way),
    .hit_ent    (hit_ent)
  );

  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic [LRU_W-1:0] lru_cur, lru_next;
  assign touch_en  = cmd_wr_fire | (lk_pend & hit_any);
  assign touch_way = lk_pend ? hit_way : dreg_q.rep;
  assign lru_next  = touch_en ? plru_touch(lru_cur, touch_way) : lru_cur;

  tlb_plru_bank #(.SETS(SETS)) u_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_sel  (act_set),
    .upd_en   (touch_en),
    .upd_bits (lru_next),
    .cur_bits (lru_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q  <= '0;
      lk_pend <= 1'b0;
      lk_cmd  <= '0;
      res_q   <= 1'b0;
    end else begin
      res_q <= lk_pend;
      if (lk_pend) begin
        lk_pend    <= 1'b0;
        dreg_q.lru <= lru_next;
        dreg_q.hit <= hit_any;
        if (hit_any) begin
          dreg_q.ppn <= hit_ent.ppn;
          dreg_q.pcd <= hit_ent.pcd;
          dreg_q.pwt <= hit_ent.pwt;
          dreg_q.rep <= hit_way;
        end
      end
      if (data_wr_fire) begin
        dreg_q.ppn <= wdata[31:PAGE_LSB];
        dreg_q.pcd <= wdata[11];
        dreg_q.pwt <= wdata[10];
        dreg_q.rep <= wdata[3:2];
        dreg_q.hit <= 1'b0;
      end
      if (cmd_wr_fire) dreg_q.lru <= lru_next;
      if (cmd_lk_fire) begin
        lk_pend <= 1'b1;
        lk_cmd  <= wdata;
      end
    end
  end

  assign rd_data   = pack_data(dreg_q);
  assign busy      = lk_pend;
  assign res_valid = res_q;
endmodule

// File: rtl/tlb_test_port_chk.sv
module tlb_test_port_chk
  import tlb_tp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             priv_ok,
  input logic             flush,
  input logic             lk_pend,
  input logic             res_valid,
  input logic [31:0]      rd_data,
  input logic             any_valid,
  input logic [WAYS-1:0]  hit_vec,
  input logic             hit_any,
  input logic [WAY_W-1:0] hit_way
);
  a_r3_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    lk_pend |=> !lk_pend);
  a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_pend |=> res_valid);
  a_r3_result_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_pend));
  a_r4_hit_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pend && hit_any) |=> (rd_data[4] && rd_data[3:2] == $past(hit_way)));
  a_r5_miss_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pend && !hit_any) |=> !rd_data[4]);
  a_r7_lowest_way: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pend && hit_vec[0]) |-> hit_way == '0);
  a_r9_priv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_ok && !lk_pend) |=> $stable(rd_data));
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_valid);
endmodule

bind tlb_test_port tlb_test_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .priv_ok   (priv_ok),
  .flush     (flush),
  .lk_pend   (lk_pend),
  .res_valid (res_valid),
  .rd_data   (rd_data),
  .any_valid (any_valid),
  .hit_vec   (hit_vec),
  .hit_any   (hit_any),
  .hit_way   (hit_way)
);

// File: tb/sim_tlb_test_port.sv
`timescale 1ns/1ps
module sim_tlb_test_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_ok = 1'b1;
  logic        flush = 1'b0;
  logic        wr_cmd = 1'b0;
  logic        wr_data = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        busy, res_valid;

  always #2.5 clk = ~clk;

  tlb_test_port u0 (.*);

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R12";
  bit    done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [19:0] m_vpn [32];
  logic [19:0] m_ppn [32];
  logic        m_vld [32];
  logic        m_d [32], m_u [32], m_w [32], m_pcd [32], m_pwt [32];
  logic [2:0]  m_lru [8];
  logic [19:0] d_ppn;
  logic        d_pcd, d_pwt, d_hit;
  logic [2:0]  d_lru;
  logic [1:0]  d_rep;
  logic        m_pend, m_rv;
  logic [31:0] m_cmd;

  function automatic bit m_pair(input logic [1:0] p, input logic s);
    if (p == 2'b11) return 1'b1;
    if (p == 2'b10) return s == 1'b1;
    if (p == 2'b01) return s == 1'b0;
    return 1'b0;
  endfunction

  function automatic logic [2:0] m_touch(input logic [2:0] s, input int w);
    logic [2:0] r = s;
    if (w < 2) begin r[0] = 1'b1; r[1] = (w == 0); end
    else       begin r[0] = 1'b0; r[2] = (w == 2); end
    return r;
  endfunction

  function automatic logic [31:0] m_rd();
    return {d_ppn, d_pcd, d_pwt, d_lru, 2'b00, d_hit, d_rep, 2'b00};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
      for (int i = 0; i < 8; i++) m_lru[i] = 3'd0;
      d_ppn = '0; d_pcd = 0; d_pwt = 0; d_hit = 0; d_lru = 0; d_rep = 0;
      m_pend = 0; m_rv = 0; m_cmd = '0;
    end else begin
      bit ok, nrv;
      ok  = priv_ok && !m_pend;
      nrv = 1'b0;
      if (m_pend) begin
        int s, found;
        s = int'(m_cmd[14:12]);
        found = -1;
        for (int w = 0; w < 4; w++) begin
          int ix;
          ix = s * 4 + w;
          if (found < 0 && m_vld[ix] && m_vpn[ix] == m_cmd[31:12] &&
              m_pair(m_cmd[10:9], m_d[ix]) && m_pair(m_cmd[8:7], m_u[ix]) &&
              m_pair(m_cmd[6:5], m_w[ix]))
            found = w;
        end
        if (found >= 0) begin
          int ix;
          ix = s * 4 + found;
          d_hit = 1; d_ppn = m_ppn[ix]; d_pcd = m_pcd[ix]; d_pwt = m_pwt[ix];
          d_rep = 2'(found);
          m_lru[s] = m_touch(m_lru[s], found);
        end else d_hit = 0;
        d_lru = m_lru[s];
        nrv = 1'b1;
        m_pend = 1'b0;
      end
      if (ok && wr_data) begin
        d_ppn = wdata[31:12]; d_pcd = wdata[11]; d_pwt = wdata[10];
        d_rep = wdata[3:2]; d_hit = 0;
      end
      if (ok && wr_cmd) begin
        if (wdata[0]) begin
          m_pend = 1'b1; m_cmd = wdata;
        end else begin
          int s, ix;
          s = int'(wdata[14:12]);
          ix = s * 4 + int'(d_rep);
          if (!flush) begin
            m_vld[ix] = wdata[11]; m_vpn[ix] = wdata[31:12];
            m_d[ix] = wdata[10]; m_u[ix] = wdata[8]; m_w[ix] = wdata[6];
            m_ppn[ix] = d_ppn; m_pcd[ix] = d_pcd; m_pwt[ix] = d_pwt;
          end
          m_lru[s] = m_touch(m_lru[s], int'(d_rep));
          d_lru = m_lru[s];
        end
      end
      if (flush) for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
      m_rv = nrv;
    end
  end

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " rd_data"}, rd_data, m_rd());
      chk({cur_req, " busy"}, {31'd0, busy}, {31'd0, m_pend});
      chk({cur_req, " res_valid"}, {31'd0, res_valid}, {31'd0, m_rv});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic data_wr(input logic [31:0] v);
    @(negedge clk); wr_data = 1'b1; wdata = v;
    @(negedge clk); wr_data = 1'b0;
  endtask

  task automatic cmd_wr(input logic [31:0] v);
    @(negedge clk); wr_cmd = 1'b1; wdata = v;
    @(negedge clk); wr_cmd = 1'b0;
  endtask

  // Returns at the sample point where the result is present
  task automatic lookup(input string req, input logic [31:0] v);
    cmd_wr(v);
    chk({req, " busy during lookup"}, {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk({req, " res_valid pulse"}, {31'd0, res_valid}, 32'd1);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 rd_data after reset", rd_data, 32'h0);
    chk("R12 busy after reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: data register layout, dropped bits
    cur_req = "R1";
    data_wr(32'hABCDEFFF);
    chk("R1 data readback", rd_data, 32'hABCDEC0C);

    // R2 / R8: install set3 way1, dirty set, user clear, writable set
    cur_req = "R2";
    data_wr(32'h12345404);
    cmd_wr(32'h00003CC0);
    chk("R2 R8 install reports lru", rd_data, 32'h12345484);

    // R3 / R4: exact-pattern lookup
    cur_req = "R4";
    lookup("R3", 32'h00003CC1);
    chk("R4 exact hit", rd_data, 32'h12345494);

    // R6: all don't-care
    cur_req = "R6";
    lookup("R6", 32'h000037E1);
    chk("R6 pair 11 hits", {31'd0, rd_data[4]}, 32'd1);

    // R5 / R6: demand user set against stored clear -> miss, fields kept
    cur_req = "R5";
    data_wr(32'h77777000);
    lookup("R5", 32'h00003541);
    chk("R5 R6 demand-set miss keeps fields", rd_data, 32'h77777080);

    // R6: pair 00 never matches
    lookup("R6", 32'h000031E1);
    chk("R6 pair 00 forces miss", {31'd0, rd_data[4]}, 32'd0);

    // R4: different tag, same set
    cur_req = "R4";
    lookup("R4", 32'h000137E1);
    chk("R4 tag mismatch misses", {31'd0, rd_data[4]}, 32'd0);

    // R7: same page in ways 2 and 0 of set 5
    cur_req = "R7";
    data_wr(32'hAAAAA008);
    cmd_wr(32'h00005B20);
    chk("R8 lru after way2 install", {29'd0, rd_data[9:7]}, 32'd4);
    data_wr(32'hBBBBB000);
    cmd_wr(32'h00005B20);
    chk("R8 lru after way0 install", {29'd0, rd_data[9:7]}, 32'd7);
    lookup("R7", 32'h000057E1);
    chk("R7 lowest way ppn", {12'd0, rd_data[31:12]}, 32'h000BBBBB);
    chk("R7 lowest way index", {30'd0, rd_data[3:2]}, 32'd0);

    // R8: walk the tree in set 5
    cur_req = "R8";
    data_wr(32'hCCCCC00C);
    cmd_wr(32'h0000DB20);
    chk("R8 lru after way3 install", {29'd0, rd_data[9:7]}, 32'd2);
    lookup("R8", 32'h0000D7E1);
    chk("R8 hit way3 keeps lru", rd_data, 32'hCCCCC11C);
    lookup("R8", 32'h000057E1);
    chk("R8 hit way0 lru", {29'd0, rd_data[9:7]}, 32'd3);

    // R2: entry installed with valid 0 never hits
    cur_req = "R2";
    data_wr(32'h11111000);
    cmd_wr(32'h000067E0);
    lookup("R2", 32'h000067E1);
    chk("R2 invalid entry misses", {31'd0, rd_data[4]}, 32'd0);

    // R9: privilege low
    cur_req = "R9";
    keep = rd_data;
    @(negedge clk); priv_ok = 1'b0;
    data_wr(32'hFFFFF000);
    chk("R9 data write ignored", rd_data, keep);
    cmd_wr(32'h00003CC1);
    chk("R9 lookup not started", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R9 no result", {31'd0, res_valid}, 32'd0);
    priv_ok = 1'b1;

    // R10: writes during busy are ignored
    cur_req = "R10";
    data_wr(32'h22222000);
    @(negedge clk); wr_cmd = 1'b1; wdata = 32'h000077E1;
    @(negedge clk); wr_cmd = 1'b0; wr_data = 1'b1; wdata = 32'h55555000;
    @(negedge clk); wr_data = 1'b0;
    chk("R10 result present", {31'd0, res_valid}, 32'd1);
    chk("R10 busy write dropped", {12'd0, rd_data[31:12]}, 32'h00022222);

    // R11: flush
    cur_req = "R11";
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    lookup("R11", 32'h000037E1);
    chk("R11 flushed entry misses", {31'd0, rd_data[4]}, 32'd0);
    data_wr(32'h99999004);
    @(negedge clk); flush = 1'b1; wr_cmd = 1'b1; wdata = 32'h00003CC0;
    @(negedge clk); flush = 1'b0; wr_cmd = 1'b0;
    lookup("R11", 32'h000037E1);
    chk("R11 flush beats install", {31'd0, rd_data[4]}, 32'd0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule